// File: doc/BRIEF.md
# Four-Bit Up/Down Toggle Counter

This block keeps a small binary count that moves by at most one step on each rising clock edge. Two control inputs select the step. An up request adds one. A down request subtracts one. With neither request the count stays where it is. When both requests are high, the up request wins.

The count lives in toggle-style state bits, and each bit has its own toggle enable. Two carry-style chains compute these enables. The increment chain marks the bits that flip when one is added. The decrement chain marks the bits that flip when one is subtracted. A small decoder turns the two requests into one of three named modes:

- `MODE_HOLD` (neither request).
- `MODE_DOWN` (down only).
- `MODE_UP` (up, with or without down).

The mode selects which chain drives the toggle enables. The only transitions are increment, decrement and hold between adjacent count values, plus the wrap from all ones to zero and from zero to all ones. A synchronous reset clears the count.

Top module: `updn_tcount`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge, whatever `up_i` and `dn_i` are.
- R2: With `up_i`=0 and `dn_i`=0 (mode `MODE_HOLD`), the count keeps its value across the edge.
- R3: With `up_i`=0 and `dn_i`=1 (mode `MODE_DOWN`), the count becomes the previous count minus one, modulo 16.
- R4: With `up_i`=1 (mode `MODE_UP`), the count becomes the previous count plus one, modulo 16. This holds for either value of `dn_i`.
- R5: On an increment, bit 0 always flips. Bit i>0 flips only when every bit below it was 1.
- R6: On a decrement, bit 0 always flips. Bit i>0 flips only when every bit below it was 0.
- R7: Incrementing 15 gives 0, and decrementing 0 gives 15.
- R8: The count changes only at a rising clock edge. It changes by exactly one step or not at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| up_i | input | 1 | Increment request, has priority |
| dn_i | input | 1 | Decrement request, used when `up_i` is low |
| count_o | output | 4 | Current count, bit 0 least significant |

## Verification
Every cycle, the assertions compare the toggle-built count against plain add, subtract and hold. They also check that reset clears the count and that only bits whose toggle enable was high have flipped. The bench starts from each of the 16 count values and applies each of the four request combinations. For every step it computes the flip mask and the wrap cases from arithmetic. It also shows that reset overrides an active up request. These last points are what only the bench scenarios can show.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_DOWN = 2'd1,
        MODE_UP   = 2'd2
    } step_mode_e;
endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic       up_i,
    input  logic       dn_i,
    output step_mode_e mode_o
);
    always_comb begin
        mode_o = MODE_HOLD;
        unique casez ({up_i, dn_i})
            2'b1?:   mode_o = MODE_UP;    // up wins over down
            2'b01:   mode_o = MODE_DOWN;
            2'b00:   mode_o = MODE_HOLD;
            default: mode_o = MODE_HOLD;
        endcase
    end
endmodule

// File: rtl/updn_toggle_terms.sv
module updn_toggle_terms #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt_i,
    output logic [WIDTH-1:0] inc_tog_o,
    output logic [WIDTH-1:0] dec_tog_o
);
    // Each chain link extends the previous one by one more lower bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        if (i == 0) begin : g_lsb
            assign inc_tog_o[i] = 1'b1;
            assign dec_tog_o[i] = 1'b1;
        end else begin : g_upper
            assign inc_tog_o[i] = inc_tog_o[i-1] &  cnt_i[i-1];
            assign dec_tog_o[i] = dec_tog_o[i-1] & ~cnt_i[i-1];
        end
    end
endmodule

// File: rtl/updn_tbit.sv
module updn_tbit (
    input  logic clk,
    input  logic rst,
    input  logic tog_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (tog_i) q_o <= ~q_o;
    end
endmodule

// File: rtl/updn_tcount.sv
module updn_tcount
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_i,
    input  logic             dn_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    step_mode_e       mode;
    logic [WIDTH-1:0] inc_tog;
    logic [WIDTH-1:0] dec_tog;
    logic [WIDTH-1:0] tog;

    updn_mode_dec u_mode (
        .up_i   (up_i),
        .dn_i   (dn_i),
        .mode_o (mode)
    );

    updn_toggle_terms #(.WIDTH(WIDTH)) u_terms (
        .cnt_i     (count_o),
        .inc_tog_o (inc_tog),
        .dec_tog_o (dec_tog)
    );

    // The mode decides which chain drives the toggle enables.
    always_comb begin
        tog = '0;
        unique case (mode)
            MODE_UP:   tog = inc_tog;
            MODE_DOWN: tog = dec_tog;
            MODE_HOLD: tog = '0;
            default:   tog = '0;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        updn_tbit u_bit (
            .clk   (clk),
            .rst   (rst),
            .tog_i (tog[i]),
            .q_o   (count_o[i])
        );
    end

    // R1: reset clears the count
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (count_o == '0));
    // R2: hold keeps the value
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!up_i && !dn_i) |=> $stable(count_o));
    // R3: decrement matches subtraction
    p_down_sub_r3: assert property (@(posedge clk) disable iff (rst)
        (!up_i && dn_i) |=> (count_o == $past(count_o) - ONE));
    // R4: increment matches addition, regardless of dn_i
    p_up_add_r4: assert property (@(posedge clk) disable iff (rst)
        up_i |=> (count_o == $past(count_o) + ONE));
    // R8: only bits whose toggle enable was high have flipped
    p_flip_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((count_o ^ $past(count_o)) & ~$past(tog)) == '0));
    // R5: an increment always flips bit 0
    p_inc_lsb_r5: assert property (@(posedge clk) disable iff (rst)
        up_i |=> (count_o[0] != $past(count_o[0])));
endmodule

// File: tb/updn_tcount_bench.sv
module updn_tcount_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_i = 1'b0;
    logic       dn_i = 1'b0;
    logic [3:0] count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    updn_tcount u_updn_tcount (
        .clk     (clk),
        .rst     (rst),
        .up_i    (up_i),
        .dn_i    (dn_i),
        .count_o (count_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock step: drive at the falling edge, sample 2 ns after the rising edge.
    task automatic step(input logic r, input logic u, input logic d);
        @(negedge clk);
        rst  = r;
        up_i = u;
        dn_i = d;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] prev;
        logic [3:0] mask;
        step(1'b1, 1'b0, 1'b0);
        check("R1 reset state", count_o, 4'd0);

        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 4; c++) begin
                step(1'b1, 1'b0, 1'b0);
                for (int k = 0; k < s; k++) step(1'b0, 1'b1, 1'b0);
                check("R4 reach start", count_o, 4'(s));
                prev = count_o;
                step(1'b0, c[1], c[0]);
                if (c[1]) begin
                    check("R4 increment", count_o, 4'(s + 1));
                    mask = 4'(((s + 1) ^ s));
                    check("R5 increment flip mask", count_o ^ prev, mask);
                    if (s == 15) check("R7 wrap up", count_o, 4'd0);
                end else if (c[0]) begin
                    check("R3 decrement", count_o, 4'(s - 1));
                    mask = 4'(((s - 1) ^ s));
                    check("R6 decrement flip mask", count_o ^ prev, mask);
                    if (s == 0) check("R7 wrap down", count_o, 4'd15);
                end else begin
                    check("R2 hold", count_o, 4'(s));
                end
                // R8: no change between edges
                #3;
                check("R8 stable between edges", count_o, (c == 0) ? 4'(s) :
                      (c[1] ? 4'(s + 1) : 4'(s - 1)));
            end
        end

        // R1: reset overrides an active up request
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        check("R1 reset overrides up", count_o, 4'd0);
        step(1'b1, 1'b0, 1'b1);
        check("R1 reset overrides down", count_o, 4'd0);
        finish_run();
    end
endmodule